// File: doc/BRIEF.md
# Loopback Transfer Timestamp Tracker

This block observes the two handshaked 32-bit word streams of a host loopback test: words uploaded from the host into the fabric, and words later returned to the host. A run begins with a start pulse that carries a sector count n. Each sector holds 1024 words. The block expects all n*1024 upload words first and then the same number of download words. It keeps a word count for each direction.

A free-running cycle counter provides the time base. The block captures this counter when four events occur: the first and the last accepted upload word, and the first and the last accepted download word. From these captures it derives the upload span, the download span and the end-to-end span. Host throughput can therefore be measured from hardware cycle counts instead of software timers. When the final download word is accepted, a done flag rises. The done flag, the timestamps and the spans then hold until the next start pulse.

Top module: `xfer_stamp_top`

## Requirements
- R1: After reset, done and proto_err are 0 and all four timestamps read 0.
- R2: A word is accepted in a direction only in a cycle where both its valid and its ready input are high. Valid high with ready low does not count, and ready high with valid low does not count.
- R3: A start pulse loads sector_count and clears the four timestamps, done and proto_err. Each direction then expects sector_count*1024 words. Handshakes in the start cycle itself are not counted.
- R4: ts_up_first holds the cycle-counter value of the cycle in which the first upload word is accepted. ts_up_last holds the value for upload word number sector_count*1024. upload_elapsed equals ts_up_last minus ts_up_first, modulo 2^32.
- R5: Download words are accepted only after the last upload word. ts_dn_first and ts_dn_last stamp the first and the final download word in the same way as R4, so ts_dn_first minus ts_up_last equals the number of cycles between those two handshakes. download_elapsed equals ts_dn_last minus ts_dn_first.
- R6: total_elapsed equals ts_dn_last minus ts_up_first, modulo 2^32.
- R7: dn_valid high during the upload phase sets proto_err. The offered word is not counted. proto_err stays set until the next start pulse.
- R8: A start pulse with a sector count of 0 gives done = 1 in the following cycle, with all timestamps and spans at 0.
- R9: done rises right after the clock edge that accepts the final download word. done, the timestamps and the spans then hold, and further words in either direction have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| sector_count | input | 16 | Number of 1024-word sectors, sampled on start |
| up_valid | input | 1 | Upload word offered |
| up_ready | input | 1 | Upload word taken by the sink |
| dn_valid | input | 1 | Download word offered |
| dn_ready | input | 1 | Download word taken by the host side |
| done | output | 1 | Run complete |
| proto_err | output | 1 | Sticky: a download word was offered during upload |
| ts_up_first | output | 32 | Time of the first upload word |
| ts_up_last | output | 32 | Time of the last upload word |
| ts_dn_first | output | 32 | Time of the first download word |
| ts_dn_last | output | 32 | Time of the last download word |
| upload_elapsed | output | 32 | ts_up_last - ts_up_first |
| download_elapsed | output | 32 | ts_dn_last - ts_dn_first |
| total_elapsed | output | 32 | ts_dn_last - ts_up_first |

## Verification
Every result is registered once: a timestamp, the done flag and proto_err all change on the same clock edge that sees the triggering handshake or start pulse, and the spans follow combinationally from the timestamps. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each check sees the state exactly one edge after its stimulus. Expected spans are computed from the cycle index of each handshake that the bench itself scheduled. For example, with one accepted word every third cycle the upload span is 3*(words-1), and a run with no gap between directions places the first download one cycle after the last upload.

// File: rtl/xfer_stamp_pkg.sv
package xfer_stamp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_UPLOAD   = 3'd1,
        PH_WAIT_DL  = 3'd2,
        PH_DOWNLOAD = 3'd3,
        PH_DONE     = 3'd4
    } phase_e;

    localparam int STAMP_UP_FIRST = 0;
    localparam int STAMP_UP_LAST  = 1;
    localparam int STAMP_DN_FIRST = 2;
    localparam int STAMP_DN_LAST  = 3;
    localparam int NUM_STAMPS     = 4;

    localparam int LANE_UP = 0;
    localparam int LANE_DN = 1;
    localparam int NUM_LANES = 2;

endpackage

// File: rtl/xfer_stamp_timebase.sv
module xfer_stamp_timebase #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);

    logic [TS_W-1:0] tick_d, tick_q;

    always_comb begin
        tick_d = tick_q + TS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    assign now = tick_q;

endmodule

// File: rtl/xfer_stamp_wordctr.sv
module xfer_stamp_wordctr #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [CNT_W-1:0] target,
    output logic             is_first,
    output logic             is_last
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)     count_d = '0;
        else if (take) count_d = count_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign is_first = (count_q == '0);
    assign is_last  = (count_q == (target - CNT_W'(1)));

endmodule

// File: rtl/xfer_stamp_seq.sv
module xfer_stamp_seq
    import xfer_stamp_pkg::*;
#(
    parameter int TS_W   = 32,
    parameter int SECT_W = 16,
    parameter int WPS    = 1024,
    parameter int CNT_W  = SECT_W + $clog2(WPS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [SECT_W-1:0]                 sector_count,
    input  logic                              up_fire,
    input  logic                              dn_offer,
    input  logic                              dn_fire,
    input  logic [NUM_LANES-1:0]              lane_first,
    input  logic [NUM_LANES-1:0]              lane_last,
    input  logic [TS_W-1:0]                   now,
    output logic [NUM_LANES-1:0]              lane_take,
    output logic                              lane_clear,
    output logic [CNT_W-1:0]                  target,
    output logic [NUM_STAMPS-1:0][TS_W-1:0]   stamps,
    output logic                              proto_err,
    output logic                              done
);

    typedef struct packed {
        phase_e                            phase;
        logic                              err;
        logic [CNT_W-1:0]                  target;
        logic [NUM_STAMPS-1:0][TS_W-1:0]   stamps;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        lane_take  = '0;
        lane_clear = 1'b0;
        if (start) begin
            lane_clear = 1'b1;
            st_d.err    = 1'b0;
            st_d.stamps = '0;
            st_d.target = CNT_W'(sector_count) * CNT_W'(WPS);
            st_d.phase  = (sector_count == '0) ? PH_DONE : PH_UPLOAD;
        end else begin
            unique case (st_q.phase)
                PH_UPLOAD: begin
                    if (dn_offer) st_d.err = 1'b1;
                    if (up_fire) begin
                        lane_take[LANE_UP] = 1'b1;
                        if (lane_first[LANE_UP]) st_d.stamps[STAMP_UP_FIRST] = now;
                        if (lane_last[LANE_UP]) begin
                            st_d.stamps[STAMP_UP_LAST] = now;
                            st_d.phase = PH_WAIT_DL;
                        end
                    end
                end
                PH_WAIT_DL, PH_DOWNLOAD: begin
                    if (dn_fire) begin
                        lane_take[LANE_DN] = 1'b1;
                        if (lane_first[LANE_DN]) begin
                            st_d.stamps[STAMP_DN_FIRST] = now;
                            st_d.phase = PH_DOWNLOAD;
                        end
                        if (lane_last[LANE_DN]) begin
                            st_d.stamps[STAMP_DN_LAST] = now;
                            st_d.phase = PH_DONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, err: 1'b0, target: '0, stamps: '0};
        else        st_q <= st_d;
    end

    assign target    = st_q.target;
    assign stamps    = st_q.stamps;
    assign proto_err = st_q.err;
    assign done      = (st_q.phase == PH_DONE);

endmodule

// File: rtl/xfer_stamp_top.sv
module xfer_stamp_top
    import xfer_stamp_pkg::*;
#(
    parameter int TS_W   = 32,
    parameter int SECT_W = 16,
    parameter int WPS    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SECT_W-1:0] sector_count,
    input  logic              up_valid,
    input  logic              up_ready,
    input  logic              dn_valid,
    input  logic              dn_ready,
    output logic              done,
    output logic              proto_err,
    output logic [TS_W-1:0]   ts_up_first,
    output logic [TS_W-1:0]   ts_up_last,
    output logic [TS_W-1:0]   ts_dn_first,
    output logic [TS_W-1:0]   ts_dn_last,
    output logic [TS_W-1:0]   upload_elapsed,
    output logic [TS_W-1:0]   download_elapsed,
    output logic [TS_W-1:0]   total_elapsed
);

    localparam int CNT_W = SECT_W + $clog2(WPS);

    logic [TS_W-1:0]                 now;
    logic [NUM_LANES-1:0]            lane_take, lane_first, lane_last;
    logic                            lane_clear;
    logic [CNT_W-1:0]                target;
    logic [NUM_STAMPS-1:0][TS_W-1:0] stamps;

    xfer_stamp_timebase #(.TS_W(TS_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        xfer_stamp_wordctr #(.CNT_W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (lane_clear),
            .take     (lane_take[g]),
            .target   (target),
            .is_first (lane_first[g]),
            .is_last  (lane_last[g])
        );
    end

    xfer_stamp_seq #(
        .TS_W   (TS_W),
        .SECT_W (SECT_W),
        .WPS    (WPS),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sector_count (sector_count),
        .up_fire      (up_valid && up_ready),
        .dn_offer     (dn_valid),
        .dn_fire      (dn_valid && dn_ready),
        .lane_first   (lane_first),
        .lane_last    (lane_last),
        .now          (now),
        .lane_take    (lane_take),
        .lane_clear   (lane_clear),
        .target       (target),
        .stamps       (stamps),
        .proto_err    (proto_err),
        .done         (done)
    );

    assign ts_up_first      = stamps[STAMP_UP_FIRST];
    assign ts_up_last       = stamps[STAMP_UP_LAST];
    assign ts_dn_first      = stamps[STAMP_DN_FIRST];
    assign ts_dn_last       = stamps[STAMP_DN_LAST];
    assign upload_elapsed   = ts_up_last - ts_up_first;
    assign download_elapsed = ts_dn_last - ts_dn_first;
    assign total_elapsed    = ts_dn_last - ts_up_first;

endmodule

// File: rtl/xfer_stamp_checker.sv
module xfer_stamp_checker #(
    parameter int TS_W   = 32,
    parameter int SECT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [SECT_W-1:0] sector_count,
    input logic              done,
    input logic              proto_err,
    input logic [TS_W-1:0]   ts_up_first,
    input logic [TS_W-1:0]   ts_up_last,
    input logic [TS_W-1:0]   ts_dn_first,
    input logic [TS_W-1:0]   ts_dn_last,
    input logic [TS_W-1:0]   upload_elapsed,
    input logic [TS_W-1:0]   total_elapsed
);

    // R7: the error flag is sticky between start pulses
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err && !start |=> proto_err);

    // R9: completion holds until restarted
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    // R9: captured times are frozen once complete
    p_stamps_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> $stable(ts_up_first) && $stable(ts_up_last)
                           && $stable(ts_dn_first) && $stable(ts_dn_last));

    // R8: empty run completes at once with nothing stamped
    p_zero_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && sector_count == '0 |=> done && ts_up_first == '0 && ts_dn_last == '0);

    // R3: start clears flags and stamps
    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !proto_err && ts_up_first == '0 && ts_up_last == '0
                  && ts_dn_first == '0 && ts_dn_last == '0);

    // R3: a non-empty run is not complete right after start
    p_start_not_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start && sector_count != '0 |=> !done);

    // R6: end-to-end span covers the upload span
    p_total_covers_upload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> total_elapsed >= upload_elapsed);

endmodule

bind xfer_stamp_top xfer_stamp_checker #(.TS_W(TS_W), .SECT_W(SECT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .sector_count   (sector_count),
    .done           (done),
    .proto_err      (proto_err),
    .ts_up_first    (ts_up_first),
    .ts_up_last     (ts_up_last),
    .ts_dn_first    (ts_dn_first),
    .ts_dn_last     (ts_dn_last),
    .upload_elapsed (upload_elapsed),
    .total_elapsed  (total_elapsed)
);

// File: tb/xfer_stamp_top_tb_top.sv
module xfer_stamp_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WPS        = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] sector_count = '0;
    logic        up_valid = 1'b0, up_ready = 1'b0;
    logic        dn_valid = 1'b0, dn_ready = 1'b0;
    logic        done, proto_err;
    logic [31:0] ts_up_first, ts_up_last, ts_dn_first, ts_dn_last;
    logic [31:0] upload_elapsed, download_elapsed, total_elapsed;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_stamp_top dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (start),
        .sector_count     (sector_count),
        .up_valid         (up_valid),
        .up_ready         (up_ready),
        .dn_valid         (dn_valid),
        .dn_ready         (dn_ready),
        .done             (done),
        .proto_err        (proto_err),
        .ts_up_first      (ts_up_first),
        .ts_up_last       (ts_up_last),
        .ts_dn_first      (ts_dn_first),
        .ts_dn_last       (ts_dn_last),
        .upload_elapsed   (upload_elapsed),
        .download_elapsed (download_elapsed),
        .total_elapsed    (total_elapsed)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(int n);
        start = 1'b1;
        sector_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    // mode 0: every cycle; mode 1: one handshake every third cycle
    task automatic stream_up(int words, int mode);
        int got = 0;
        int cyc = 0;
        while (got < words) begin
            if (mode == 0) begin up_valid = 1'b1; up_ready = 1'b1; end
            else begin
                up_valid = (cyc % 3) != 1;
                up_ready = (cyc % 3) != 0;
            end
            if (up_valid && up_ready) got++;
            cyc++;
            @(negedge clk);
        end
        up_valid = 1'b0;
        up_ready = 1'b0;
    endtask

    task automatic stream_dn(int words);
        for (int i = 0; i < words; i++) begin
            dn_valid = 1'b1;
            dn_ready = 1'b1;
            @(negedge clk);
        end
        dn_valid = 1'b0;
        dn_ready = 1'b0;
    endtask

    task automatic idle(int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "done", 32'(done), 0);
        check("R1", "proto_err", 32'(proto_err), 0);
        check("R1", "ts_up_first", ts_up_first, 0);
        check("R1", "ts_dn_last", ts_dn_last, 0);
    endtask

    task automatic t_basic;
        int gap = 5;
        pulse_start(1);
        check("R3", "done after start", 32'(done), 0);
        stream_up(WPS, 0);
        check("R9", "done before download", 32'(done), 0);
        idle(gap);
        stream_dn(WPS);
        check("R4", "upload_elapsed", upload_elapsed, WPS - 1);
        check("R5", "download_elapsed", download_elapsed, WPS - 1);
        check("R5", "dn_first - up_last", ts_dn_first - ts_up_last, gap + 1);
        check("R6", "total_elapsed", total_elapsed, 2 * WPS + gap - 1);
        check("R9", "done", 32'(done), 1);
        check("R7", "no error", 32'(proto_err), 0);
    endtask

    task automatic t_stall;
        pulse_start(2);
        stream_up(2 * WPS, 1);
        stream_dn(2 * WPS);
        check("R2", "upload_elapsed with stalls", upload_elapsed, 3 * (2 * WPS - 1));
        check("R5", "download_elapsed", download_elapsed, 2 * WPS - 1);
        check("R6", "total_elapsed", total_elapsed, 3 * (2 * WPS - 1) + 1 + 2 * WPS - 1);
        check("R9", "done", 32'(done), 1);
    endtask

    task automatic t_early_dn;
        pulse_start(1);
        stream_dn(3);
        check("R7", "proto_err set", 32'(proto_err), 1);
        check("R7", "early dn not stamped", ts_dn_first, 0);
        stream_up(WPS, 0);
        stream_dn(WPS - 1);
        check("R7", "early words not counted (done)", 32'(done), 0);
        stream_dn(1);
        check("R9", "done on final word", 32'(done), 1);
        check("R7", "proto_err sticky", 32'(proto_err), 1);
        check("R5", "download_elapsed", download_elapsed, WPS - 1);
    endtask

    task automatic t_hold;
        logic [31:0] up_e = upload_elapsed;
        logic [31:0] tot  = total_elapsed;
        logic [31:0] dl   = ts_dn_last;
        stream_up(5, 0);
        stream_dn(5);
        check("R9", "upload_elapsed held", upload_elapsed, up_e);
        check("R9", "total_elapsed held", total_elapsed, tot);
        check("R9", "ts_dn_last held", ts_dn_last, dl);
        check("R9", "done held", 32'(done), 1);
    endtask

    task automatic t_restart;
        pulse_start(1);
        check("R3", "done cleared", 32'(done), 0);
        check("R3", "proto_err cleared", 32'(proto_err), 0);
        check("R3", "ts_up_last cleared", ts_up_last, 0);
        check("R3", "ts_dn_first cleared", ts_dn_first, 0);
    endtask

    task automatic t_zero;
        pulse_start(0);
        check("R8", "done", 32'(done), 1);
        check("R8", "ts_up_first", ts_up_first, 0);
        check("R8", "ts_dn_last", ts_dn_last, 0);
        check("R8", "total_elapsed", total_elapsed, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold();
        t_stall();
        t_early_dn();
        t_restart();
        t_zero();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule